// File: doc/BRIEF.md
# Short Forward Branch Nullification Unit

This unit sits beside the decode stage of a scalar in-order pipeline that accepts at most one instruction per cycle. A conditional branch that jumps a short distance forward causes no fetch redirect and no prediction. The unit lets the instructions that follow it keep flowing, and it marks each of them with a shadow bit. The pipeline is modelled as a parameterised chain of stages that carries these bits. The branch outcome becomes known when the branch reaches the last stage. If the branch was not taken, its shadow instructions retire unchanged. If it was taken, they become no-ops: their register write enable and memory write enable are cleared. In neither case does fetch change direction.

Only one short branch is tracked at a time. Every other conditional branch raises a request to the external predictor. This covers long branches, backward branches, and short branches that arrive while the unit is busy. A flush caused by an older mispredicted branch empties the stages and drops all tracking state. A new short branch can then be accepted in the very next cycle.

Top module: `sfb_nullify_unit`

## Requirements
- R1: After reset, `busy_o`, `res_due_o`, `ret_valid_o` and every bit of `kill_o` are 0.
- R2: A branch is accepted as short when all three of these hold: `in_offset_i`, read as a signed instruction distance from the branch to its target, is at least 2; it is at most MAX_SKIP+1 (default 2); and the unit is not busy. In the same cycle `pred_req_o` is 1 for any other valid branch and 0 for any non-branch.
- R3: The next (offset-1) valid instructions after an accepted branch are tagged as its shadow. Idle cycles do not count toward this. At most MAX_SKIP `kill_o` bits are ever set together.
- R4: `res_due_o` is 1 in the cycle the tracked branch occupies the last stage, which is NSTAGES cycles after the cycle it was presented. In that cycle, if `res_taken_i` is 1, `kill_o[s]` is set for every stage s that holds a tagged instruction. Stage index 0 is the youngest stage, so the instruction right behind the branch is bit NSTAGES-2, which is 0x40 by default. Killed instructions later retire with `ret_wb_o` and `ret_mw_o` at 0. If `res_taken_i` is 0, tagged instructions retire with their original enables.
- R5: Only one short branch is tracked at a time. While the unit is busy, a further short branch raises `pred_req_o`, is never resolved by the unit, and does not affect the instructions behind it.
- R6: `busy_o` goes to 1 in the cycle after an accept. It stays at 1 until the tracked branch has resolved and its whole shadow has entered.
- R7: Suppose a taken branch resolves before all of its shadow has entered, because of idle cycles. The shadow instructions that are still missing then enter as no-ops, with both enables cleared.
- R8: `flush_i` clears every stage, all tags and the tracking state at the next edge. While `flush_i` is 1, `ret_valid_o` and `kill_o` are 0, so a flush wins over a resolution in the same cycle. A short branch presented in the next cycle is accepted.
- R9: Instructions retire in issue order on `ret_valid_o` and `ret_id_o`, one per stage slot, and there is no output that redirects fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Flush from an older misprediction |
| in_valid_i | input | 1 | Instruction presented this cycle |
| in_branch_i | input | 1 | Instruction is a conditional branch |
| in_offset_i | input | OFF_W | Signed branch distance in instructions |
| in_wb_i | input | 1 | Instruction writes a register |
| in_mw_i | input | 1 | Instruction writes memory |
| in_id_i | input | ID_W | Instruction identifier carried to retirement |
| res_taken_i | input | 1 | Outcome of the branch in the last stage |
| pred_req_o | output | 1 | Branch handed to the external predictor |
| busy_o | output | 1 | A short branch or its shadow is still pending |
| res_due_o | output | 1 | Tracked branch is in the last stage |
| kill_o | output | NSTAGES | Per-stage nullify mask |
| ret_valid_o | output | 1 | Instruction leaving the last stage |
| ret_id_o | output | ID_W | Identifier of the retiring instruction |
| ret_wb_o | output | 1 | Register write enable after nullification |
| ret_mw_o | output | 1 | Memory write enable after nullification |

## Verification
Two functions can land in the same cycle: resolving the tracked branch as taken, and flushing from an older misprediction. The bench sets up this collision by watching `res_due_o` and raising `flush_i` in exactly that cycle with `res_taken_i` held at 1. The case is judged correct if `kill_o` stays 0, neither the branch nor its shadow ever retires, and the unit is free in the next cycle. A second collision is also provoked: a taken resolution in a cycle where the shadow is still incomplete. It is judged by requiring that the instruction arriving later retires with both enables cleared.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

   // per-stage control bits carried beside each instruction
   typedef struct packed {
      logic valid;   // slot holds an instruction
      logic sfb;     // slot holds the tracked short branch
      logic tag;     // slot is in the tracked shadow
      logic wb;      // register write enable
      logic mw;      // memory write enable
   } slot_t;

endpackage

// File: rtl/sfb_classify.sv
module sfb_classify #(
   parameter int OFF_W    = 12,
   parameter int MAX_SKIP = 1,
   parameter int CNT_W    = 1
) (
   input  logic             in_valid_i,
   input  logic             in_branch_i,
   input  logic [OFF_W-1:0] in_offset_i,
   output logic             short_o,
   output logic [CNT_W-1:0] skip_o
);

   localparam logic signed [OFF_W-1:0] LO_LIM = OFF_W'(2);
   localparam logic signed [OFF_W-1:0] HI_LIM = OFF_W'(MAX_SKIP + 1);

   logic signed [OFF_W-1:0] off_s;
   logic [OFF_W-1:0]        skip_full;

   assign off_s     = $signed(in_offset_i);
   assign skip_full = in_offset_i - OFF_W'(1);
   assign short_o   = in_valid_i && in_branch_i && (off_s >= LO_LIM) && (off_s <= HI_LIM);
   assign skip_o    = skip_full[CNT_W-1:0];

endmodule

// File: rtl/sfb_tracker.sv
module sfb_tracker #(
   parameter int CNT_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             in_valid_i,
   input  logic             short_i,
   input  logic [CNT_W-1:0] skip_i,
   input  logic             res_due_i,
   input  logic             res_taken_i,
   output logic             accept_o,
   output logic             tag_o,
   output logic             drop_o,
   output logic             busy_o
);

   logic             trk_q;
   logic             drop_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_after;
   logic             shadow_open;

   assign shadow_open = (cnt_q != '0);
   assign busy_o      = trk_q || shadow_open;
   assign accept_o    = short_i && !busy_o && !flush_i;
   assign tag_o       = in_valid_i && shadow_open;
   assign drop_o      = tag_o && (drop_q || (res_due_i && res_taken_i));
   assign cnt_after   = tag_o ? cnt_q - CNT_W'(1) : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         trk_q  <= 1'b0;
         drop_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept_o) begin
         trk_q  <= 1'b1;
         drop_q <= 1'b0;
         cnt_q  <= skip_i;
      end else begin
         if (res_due_i) trk_q <= 1'b0;
         if (res_due_i && !res_taken_i) begin
            cnt_q  <= '0;
            drop_q <= 1'b0;
         end else if (res_due_i) begin
            cnt_q  <= cnt_after;
            drop_q <= (cnt_after != '0);
         end else begin
            cnt_q <= cnt_after;
            if (cnt_after == '0) drop_q <= 1'b0;
         end
      end
   end

   // R6: an accepted branch makes the unit busy in the next cycle
   a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
      accept_o |=> busy_o);

endmodule

// File: rtl/sfb_stage_pipe.sv
module sfb_stage_pipe
   import sfb_pkg::*;
#(
   parameter int NSTAGES  = 8,
   parameter int ID_W     = 8,
   parameter int MAX_SKIP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  slot_t             ent_i,
   input  logic [ID_W-1:0]   ent_id_i,
   input  logic              res_taken_i,
   output logic              res_due_o,
   output logic [NSTAGES-1:0] kill_o,
   output slot_t             last_o,
   output logic [ID_W-1:0]   last_id_o
);

   localparam int LAST = NSTAGES - 1;

   slot_t             st  [NSTAGES];
   logic [ID_W-1:0]   sid [NSTAGES];
   logic [NSTAGES-1:0] sfb_vec;
   logic              kill_en;

   assign res_due_o = st[LAST].valid && st[LAST].sfb;
   assign kill_en   = res_due_o && res_taken_i && !flush_i;
   assign last_o    = st[LAST];
   assign last_id_o = sid[LAST];

   for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
      assign kill_o[s]  = kill_en && st[s].valid && st[s].tag;
      assign sfb_vec[s] = st[s].valid && st[s].sfb;

      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n || flush_i) begin
               st[s]  <= '0;
               sid[s] <= '0;
            end else begin
               st[s]  <= ent_i;
               sid[s] <= ent_id_i;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n || flush_i) begin
               st[s]  <= '0;
               sid[s] <= '0;
            end else begin
               st[s]    <= st[s-1];
               st[s].wb <= st[s-1].wb && !kill_o[s-1];
               st[s].mw <= st[s-1].mw && !kill_o[s-1];
               sid[s]   <= sid[s-1];
            end
         end

         // R7: a killed slot carries no write enable one stage later
         a_r7_killed_is_nop: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
            kill_o[s-1] |=> (!st[s].wb && !st[s].mw));
      end
   end

   // R5: never more than one tracked branch in flight
   a_r5_one_tracked: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sfb_vec) <= 1);

   // R3: the kill mask never covers more than the longest shadow
   a_r3_kill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(kill_o) <= MAX_SKIP);

endmodule

// File: rtl/sfb_nullify_unit.sv
module sfb_nullify_unit
   import sfb_pkg::*;
#(
   parameter int NSTAGES  = 8,
   parameter int MAX_SKIP = 1,
   parameter int OFF_W    = 12,
   parameter int ID_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic               in_valid_i,
   input  logic               in_branch_i,
   input  logic [OFF_W-1:0]   in_offset_i,
   input  logic               in_wb_i,
   input  logic               in_mw_i,
   input  logic [ID_W-1:0]    in_id_i,
   input  logic               res_taken_i,
   output logic               pred_req_o,
   output logic               busy_o,
   output logic               res_due_o,
   output logic [NSTAGES-1:0] kill_o,
   output logic               ret_valid_o,
   output logic [ID_W-1:0]    ret_id_o,
   output logic               ret_wb_o,
   output logic               ret_mw_o
);

   localparam int CNT_W = (MAX_SKIP < 2) ? 1 : $clog2(MAX_SKIP + 1);

   if (NSTAGES < 3) begin : g_bad_depth
      $error("NSTAGES must be at least 3");
   end
   if (MAX_SKIP < 1 || MAX_SKIP > NSTAGES - 2) begin : g_bad_skip
      $error("MAX_SKIP must lie in 1..NSTAGES-2");
   end
   if (OFF_W < 3 || (MAX_SKIP + 1) >= (1 << (OFF_W - 1))) begin : g_bad_off
      $error("OFF_W too narrow for MAX_SKIP");
   end

   logic             is_short;
   logic [CNT_W-1:0] skip;
   logic             accept, tag_in, drop_in;
   slot_t            ent, last;
   logic [ID_W-1:0]  last_id;

   sfb_classify #(.OFF_W(OFF_W), .MAX_SKIP(MAX_SKIP), .CNT_W(CNT_W)) u_cls (
      .in_valid_i (in_valid_i),
      .in_branch_i(in_branch_i),
      .in_offset_i(in_offset_i),
      .short_o    (is_short),
      .skip_o     (skip)
   );

   sfb_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .in_valid_i (in_valid_i),
      .short_i    (is_short),
      .skip_i     (skip),
      .res_due_i  (res_due_o),
      .res_taken_i(res_taken_i),
      .accept_o   (accept),
      .tag_o      (tag_in),
      .drop_o     (drop_in),
      .busy_o     (busy_o)
   );

   always_comb begin
      ent.valid = in_valid_i && !flush_i;
      ent.sfb   = accept;
      ent.tag   = tag_in;
      ent.wb    = in_wb_i && !drop_in;
      ent.mw    = in_mw_i && !drop_in;
   end

   sfb_stage_pipe #(.NSTAGES(NSTAGES), .ID_W(ID_W), .MAX_SKIP(MAX_SKIP)) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .ent_i      (ent),
      .ent_id_i   (in_id_i),
      .res_taken_i(res_taken_i),
      .res_due_o  (res_due_o),
      .kill_o     (kill_o),
      .last_o     (last),
      .last_id_o  (last_id)
   );

   assign pred_req_o  = in_valid_i && in_branch_i && !(is_short && !busy_o);
   assign ret_valid_o = last.valid && !flush_i;
   assign ret_id_o    = last_id;
   assign ret_wb_o    = last.wb;
   assign ret_mw_o    = last.mw;

   // R4: kill bits appear only at a taken resolution without flush
   a_r4_kill_on_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_o != '0) |-> (res_due_o && res_taken_i && !flush_i));

   // R8: a flush leaves the unit idle and empty
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (!busy_o && !res_due_o && !last.valid));

   // R2: an accepted branch never goes to the predictor
   a_r2_accept_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !pred_req_o);

endmodule

// File: tb/sim_sfb_nullify_unit.sv
module sim_sfb_nullify_unit;

   localparam int NST = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_i = 1'b0;
   logic in_valid_i = 1'b0, in_branch_i = 1'b0, in_wb_i = 1'b0, in_mw_i = 1'b0;
   logic [11:0] in_offset_i = '0;
   logic [7:0]  in_id_i = '0;
   logic res_taken_i = 1'b0;
   logic pred_req_o, busy_o, res_due_o, ret_valid_o, ret_wb_o, ret_mw_o;
   logic [NST-1:0] kill_o;
   logic [7:0] ret_id_o;

   int  n_chk = 0, n_bad = 0;
   bit  want_taken = 1'b0;
   bit  done = 1'b0;
   bit  exp_wb [256];
   bit  exp_mw [256];
   bit  seen   [256];
   logic [NST-1:0] last_kill = '0;

   always #10 clk = ~clk;   // 50 MHz

   sfb_nullify_unit u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .in_valid_i(in_valid_i), .in_branch_i(in_branch_i), .in_offset_i(in_offset_i),
      .in_wb_i(in_wb_i), .in_mw_i(in_mw_i), .in_id_i(in_id_i),
      .res_taken_i(res_taken_i), .pred_req_o(pred_req_o), .busy_o(busy_o),
      .res_due_o(res_due_o), .kill_o(kill_o), .ret_valid_o(ret_valid_o),
      .ret_id_o(ret_id_o), .ret_wb_o(ret_wb_o), .ret_mw_o(ret_mw_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // retirement monitor: compares against the branch-exact reference enables
   always @(negedge clk) begin
      if (rst_n && ret_valid_o) begin
         seen[ret_id_o] = 1'b1;
         chk(ret_wb_o == exp_wb[ret_id_o], "R4 wb", int'(ret_wb_o), int'(exp_wb[ret_id_o]));
         chk(ret_mw_o == exp_mw[ret_id_o], "R4 mw", int'(ret_mw_o), int'(exp_mw[ret_id_o]));
      end
      if (rst_n && res_due_o) last_kill = kill_o;
   end

   always @(posedge clk) begin
      #2 res_taken_i = want_taken;
   end

   task automatic put(input bit br, input int off, input bit wb, input bit mw, input int id,
                      input bit ewb, input bit emw, output bit pr);
      @(posedge clk); #2;
      in_valid_i = 1'b1; in_branch_i = br; in_offset_i = 12'(off);
      in_wb_i = wb; in_mw_i = mw; in_id_i = 8'(id);
      exp_wb[id] = ewb; exp_mw[id] = emw; seen[id] = 1'b0;
      #1 pr = pred_req_o;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         in_valid_i = 1'b0; in_branch_i = 1'b0;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(busy_o == 0, "R1 busy", int'(busy_o), 0);
      chk(ret_valid_o == 0, "R1 ret_valid", int'(ret_valid_o), 0);
      chk(kill_o == 0, "R1 kill", int'(kill_o), 0);
      chk(res_due_o == 0, "R1 res_due", int'(res_due_o), 0);
   endtask

   task automatic t_classify();
      bit pr;
      put(0, 0, 1, 0, 1, 1, 0, pr);  chk(pr == 0, "R2 non-branch", int'(pr), 0);
      put(1, 1, 0, 0, 2, 0, 0, pr);  chk(pr == 1, "R2 offset 1", int'(pr), 1);
      put(1, 3, 0, 0, 3, 0, 0, pr);  chk(pr == 1, "R2 offset 3", int'(pr), 1);
      put(1, -2, 0, 0, 4, 0, 0, pr); chk(pr == 1, "R2 backward", int'(pr), 1);
      idle(1); #1;
      chk(busy_o == 0, "R2 none accepted", int'(busy_o), 0);
      idle(NST + 2);
      chk(seen[1] && seen[4], "R9 retired", int'(seen[4]), 1);
   endtask

   task automatic t_not_taken();
      bit pr;
      want_taken = 1'b0;
      put(1, 2, 0, 0, 10, 0, 0, pr); chk(pr == 0, "R2 short accepted", int'(pr), 0);
      put(0, 0, 1, 1, 11, 1, 1, pr); chk(busy_o == 1, "R6 busy", int'(busy_o), 1);
      put(0, 0, 1, 0, 12, 1, 0, pr);
      idle(NST + 3); #1;
      chk(busy_o == 0, "R6 free after resolve", int'(busy_o), 0);
      chk(seen[11] && seen[12], "R4 not-taken retire", int'(seen[11]), 1);
   endtask

   task automatic t_taken();
      bit pr;
      want_taken = 1'b1; last_kill = '0;
      put(1, 2, 0, 0, 20, 0, 0, pr);
      put(0, 0, 1, 1, 21, 0, 0, pr);
      put(0, 0, 1, 1, 22, 1, 1, pr);
      idle(NST + 3);
      chk(last_kill == 8'h40, "R4 kill mask", int'(last_kill), 8'h40);
      chk(seen[21] && seen[22], "R9 taken retire", int'(seen[21]), 1);
   endtask

   task automatic t_back_to_back();
      bit pr;
      want_taken = 1'b1;
      put(1, 2, 0, 0, 60, 0, 0, pr);
      put(0, 0, 1, 0, 61, 0, 0, pr);
      put(1, 2, 0, 0, 62, 0, 0, pr); chk(pr == 1, "R5 second short to predictor", int'(pr), 1);
      put(0, 0, 1, 1, 63, 1, 1, pr);
      idle(NST + 3);
      chk(seen[63], "R5 follower retired", int'(seen[63]), 1);
   endtask

   task automatic t_late_shadow();
      bit pr;
      want_taken = 1'b1;
      put(1, 2, 0, 0, 70, 0, 0, pr);
      idle(NST + 1); #1;
      chk(busy_o == 1, "R6 busy until shadow", int'(busy_o), 1);
      put(0, 0, 1, 1, 71, 0, 0, pr);
      put(0, 0, 1, 0, 72, 1, 0, pr); chk(busy_o == 0, "R7 shadow closed", int'(busy_o), 0);
      idle(NST + 2);
      chk(seen[71] && seen[72], "R7 retire", int'(seen[71]), 1);
   endtask

   task automatic t_flush_shadow();
      bit pr;
      want_taken = 1'b1;
      put(1, 2, 0, 0, 40, 0, 0, pr);
      put(0, 0, 1, 0, 41, 1, 0, pr);
      @(posedge clk); #2; in_valid_i = 1'b0; flush_i = 1'b1;
      @(posedge clk); #2; flush_i = 1'b0; #1;
      chk(busy_o == 0, "R8 free after flush", int'(busy_o), 0);
      put(1, 2, 0, 0, 42, 0, 0, pr); chk(pr == 0, "R8 accept after flush", int'(pr), 0);
      put(0, 0, 1, 0, 43, 0, 0, pr);
      idle(NST + 3);
      chk(!seen[40] && !seen[41], "R8 flushed gone", int'(seen[41]), 0);
      chk(seen[43], "R8 new shadow retired", int'(seen[43]), 1);
   endtask

   task automatic t_flush_at_resolve();
      bit pr;
      bit hit = 1'b0;
      want_taken = 1'b1; last_kill = 8'hff;
      put(1, 2, 0, 0, 50, 0, 0, pr);
      put(0, 0, 1, 1, 51, 1, 1, pr);
      for (int i = 0; i < NST + 4 && !hit; i++) begin
         @(posedge clk); #2;
         in_valid_i = 1'b0;
         if (res_due_o) begin flush_i = 1'b1; hit = 1'b1; end
      end
      chk(hit, "R4 res_due reached", int'(hit), 1);
      @(posedge clk); #2; flush_i = 1'b0; #1;
      chk(busy_o == 0, "R8 free after collision", int'(busy_o), 0);
      chk(last_kill == 0, "R8 flush beats kill", int'(last_kill), 0);
      idle(NST + 2);
      chk(!seen[50] && !seen[51], "R8 nothing retired", int'(seen[50]), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_classify();
      t_not_taken();
      t_taken();
      t_back_to_back();
      t_late_shadow();
      t_flush_shadow();
      t_flush_at_resolve();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule